// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command bus of a single-data-rate SDRAM from reset until the memory can take its first row activation. After reset it holds the bus at NOP for a power-up settling period, counted in clock cycles from a parameter. It then closes every bank with a precharge-all command. Next it issues two single auto-refresh commands, each followed by the full refresh recovery time, the same way a distributed refresh would. Last, it programs the mode register with burst length, burst type and CAS latency, all taken from parameters. After the mode-register recovery time it raises a ready flag, and the main controller takes over the bus from then on.

The sequencer is a ten-state machine fed by one shared down-counter. The states are: `S_POWERUP_WAIT` (NOP until the settling count runs out), `S_PRECHARGE` (one cycle), `S_WAIT_TRP`, `S_REFRESH_A`, `S_WAIT_TRFC_A`, `S_REFRESH_B`, `S_WAIT_TRFC_B`, `S_LOAD_MODE`, `S_WAIT_TMRD` and `S_READY`. Each command state lasts one cycle and always moves to the wait state that follows it, loading the counter on the way. Each wait state moves to the next command state when the counter reads zero. `S_READY` is terminal until reset. Reset, asynchronous and active low, returns the machine to `S_POWERUP_WAIT` from any state. The parameters `T_RP`, `T_RFC` and `T_MRD` must each be at least 2, and `ADDR_W` must be at least 11.

Top module: `sdram_boot_seq`

## Requirements
- R1: While rst_n is low, the bus shows NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), addr and ba are zero, and ready is low.
- R2: After reset is released, the bus carries NOP for exactly T_POWERUP cycles. The first command, precharge-all, appears in cycle T_POWERUP, counting the first clock edge with reset released as cycle 1.
- R3: Precharge-all is encoded as cs_n=0, ras_n=0, cas_n=1, we_n=0 with addr bit 10 high, all other addr bits zero, and ba zero.
- R4: The first auto-refresh appears exactly T_RP cycles after the precharge-all.
- R5: Exactly two auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1) are issued per sequence, the second exactly T_RFC cycles after the first.
- R6: The mode-register load (all four command pins low) appears exactly T_RFC cycles after the second auto-refresh, with ba zero. The addr pins carry the burst-length code on bits 2:0, the burst type on bit 3 (1 = interleaved) and the CAS latency on bits 6:4, with all higher bits zero.
- R7: ready rises exactly T_MRD cycles after the mode-register load and stays high until reset. While ready is high, the bus carries NOP.
- R8: Every cycle that is not one of the four commands above carries NOP with addr and ba zero, and each command lasts exactly one cycle.
- R9: Asserting reset in the middle of the sequence abandons it. After release, the whole sequence restarts with the full power-up wait.
- R10: The block never drives an activate, read or write command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins (A10 flag, mode word) |
| sd_ba | output | BANK_W | Bank address pins |
| ready | output | 1 | Sequence complete; bus handed over |

## Verification
On every clock, the embedded assertions enforce the following:
- no activate, read or write pattern ever appears;
- a precharge always carries A10 high;
- a mode load always has bank zero;
- ready never falls outside reset and always coincides with NOP;
- every command is followed by a NOP;
- the shared counter steps down by one when idle.

Other properties can only be shown by the bench's per-cycle reference model and its scenarios:
- the exact cycle of each command (the power-up length and the tRP, tRFC and tMRD spacings);
- the exact bit layout of the mode word;
- that there are exactly two refreshes;
- the restart after a mid-sequence reset.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRECHARGE_ALL,
        CMD_AUTO_REFRESH,
        CMD_LOAD_MODE
    } boot_cmd_e;

    typedef enum logic [3:0] {
        S_POWERUP_WAIT,
        S_PRECHARGE,
        S_WAIT_TRP,
        S_REFRESH_A,
        S_WAIT_TRFC_A,
        S_REFRESH_B,
        S_WAIT_TRFC_B,
        S_LOAD_MODE,
        S_WAIT_TMRD,
        S_READY
    } boot_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    function automatic cmd_pins_t encode_cmd(boot_cmd_e c);
        cmd_pins_t p;
        unique case (c)
            CMD_NOP:           p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_PRECHARGE_ALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_AUTO_REFRESH:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_LOAD_MODE:     p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:           p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
    parameter int CNT_W     = 16,
    parameter int RESET_VAL = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    localparam logic [CNT_W-1:0] INIT = CNT_W'(RESET_VAL);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= INIT;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R2: an idle, non-expired counter steps down by exactly one
    p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done) |=> (cnt == $past(cnt) - 1'b1));

    // R8: a load always takes effect on the next edge
    p_timer_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
    import sdram_boot_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_RFC = 14,
    parameter int T_MRD = 2,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timer_done,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output boot_cmd_e        cmd,
    output logic             ready
);

    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP  - 2);
    localparam logic [CNT_W-1:0] RFC_LOAD = CNT_W'(T_RFC - 2);
    localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(T_MRD - 2);

    boot_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_POWERUP_WAIT;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_POWERUP_WAIT: if (timer_done) state_nx = S_PRECHARGE;
            S_PRECHARGE:    state_nx = S_WAIT_TRP;
            S_WAIT_TRP:     if (timer_done) state_nx = S_REFRESH_A;
            S_REFRESH_A:    state_nx = S_WAIT_TRFC_A;
            S_WAIT_TRFC_A:  if (timer_done) state_nx = S_REFRESH_B;
            S_REFRESH_B:    state_nx = S_WAIT_TRFC_B;
            S_WAIT_TRFC_B:  if (timer_done) state_nx = S_LOAD_MODE;
            S_LOAD_MODE:    state_nx = S_WAIT_TMRD;
            S_WAIT_TMRD:    if (timer_done) state_nx = S_READY;
            S_READY:        state_nx = S_READY;
            default:        state_nx = S_POWERUP_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        cmd        = CMD_NOP;
        timer_load = 1'b0;
        timer_val  = '0;
        ready      = 1'b0;
        unique case (state)
            S_PRECHARGE: begin
                cmd        = CMD_PRECHARGE_ALL;
                timer_load = 1'b1;
                timer_val  = RP_LOAD;
            end
            S_REFRESH_A, S_REFRESH_B: begin
                cmd        = CMD_AUTO_REFRESH;
                timer_load = 1'b1;
                timer_val  = RFC_LOAD;
            end
            S_LOAD_MODE: begin
                cmd        = CMD_LOAD_MODE;
                timer_load = 1'b1;
                timer_val  = MRD_LOAD;
            end
            S_READY:  ready = 1'b1;
            default: ;
        endcase
    end

    // R7: once ready, stays ready until reset
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R8: every command is a single cycle followed by NOP
    p_cmd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    // R4: refresh only after the precharge recovery wait
    p_ref_after_trp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_TRP && timer_done) |=> (state == S_REFRESH_A));

    // R6: mode load only after the second refresh recovery wait
    p_mode_after_trfc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD_MODE) |-> ($past(state) == S_WAIT_TRFC_B));

endmodule

// File: rtl/sdram_cmd_pins.sv
module sdram_cmd_pins
    import sdram_boot_pkg::*;
#(
    parameter int         ADDR_W           = 13,
    parameter int         BANK_W           = 2,
    parameter logic [2:0] BURST_LEN_CODE   = 3'b011,
    parameter logic       BURST_INTERLEAVE = 1'b0,
    parameter logic [2:0] CAS_LATENCY      = 3'b011
) (
    input  boot_cmd_e         cmd,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);

    localparam int PRE_BIT = 10;
    localparam logic [6:0] MODE_LOW = {CAS_LATENCY, BURST_INTERLEAVE, BURST_LEN_CODE};

    cmd_pins_t pins;

    always_comb begin
        pins  = encode_cmd(cmd);
        cs_n  = pins.cs_n;
        ras_n = pins.ras_n;
        cas_n = pins.cas_n;
        we_n  = pins.we_n;
    end

    // per-bit address selection: mode word low bits, precharge flag bit, zero elsewhere
    for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
        if (i < 7) begin : g_mode
            assign addr[i] = (cmd == CMD_LOAD_MODE) ? MODE_LOW[i] : 1'b0;
        end else if (i == PRE_BIT) begin : g_pre
            assign addr[i] = (cmd == CMD_PRECHARGE_ALL);
        end else begin : g_zero
            assign addr[i] = 1'b0;
        end
    end

    assign ba = '0;

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int         ADDR_W           = 13,
    parameter int         BANK_W           = 2,
    parameter int         T_POWERUP        = 20000,
    parameter int         T_RP             = 3,
    parameter int         T_RFC            = 14,
    parameter int         T_MRD            = 2,
    parameter logic [2:0] BURST_LEN_CODE   = 3'b011,
    parameter logic       BURST_INTERLEAVE = 1'b0,
    parameter logic [2:0] CAS_LATENCY      = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic              ready
);

    localparam int LONG_A  = (T_POWERUP > T_RFC) ? T_POWERUP : T_RFC;
    localparam int LONG_B  = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
    localparam int CNT_W   = $clog2(LONGEST + 1) + 1;

    logic             timer_done;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    boot_cmd_e        cmd;

    sdram_boot_timer #(
        .CNT_W    (CNT_W),
        .RESET_VAL(T_POWERUP - 1)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .load_val(timer_val),
        .done    (timer_done)
    );

    sdram_boot_fsm #(
        .T_RP (T_RP),
        .T_RFC(T_RFC),
        .T_MRD(T_MRD),
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_done(timer_done),
        .timer_load(timer_load),
        .timer_val (timer_val),
        .cmd       (cmd),
        .ready     (ready)
    );

    sdram_cmd_pins #(
        .ADDR_W          (ADDR_W),
        .BANK_W          (BANK_W),
        .BURST_LEN_CODE  (BURST_LEN_CODE),
        .BURST_INTERLEAVE(BURST_INTERLEAVE),
        .CAS_LATENCY     (CAS_LATENCY)
    ) u_pins (
        .cmd  (cmd),
        .cs_n (sd_cs_n),
        .ras_n(sd_ras_n),
        .cas_n(sd_cas_n),
        .we_n (sd_we_n),
        .addr (sd_addr),
        .ba   (sd_ba)
    );

    // R10: never an activate
    p_no_activate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n));

    // R10: never a read or write
    p_no_rdwr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sd_cs_n && sd_ras_n && !sd_cas_n));

    // R3: precharge always carries the all-banks flag
    p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[10]);

    // R6: mode load is driven with bank zero
    p_mode_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n) |-> (sd_ba == '0));

    // R7: bus is idle once handed over
    p_ready_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n));

endmodule

// File: tb/sdram_boot_seq_tb.sv
module sdram_boot_seq_tb;

    localparam int         AW   = 13;
    localparam int         BW   = 2;
    localparam int         TPU  = 20000;
    localparam int         TRP  = 4;
    localparam int         TRFC = 14;
    localparam int         TMRD = 2;
    localparam logic [2:0] BL   = 3'b010;
    localparam logic       BT   = 1'b1;
    localparam logic [2:0] CL   = 3'b010;

    localparam int N_PRE  = TPU;
    localparam int N_REF1 = N_PRE + TRP;
    localparam int N_REF2 = N_REF1 + TRFC;
    localparam int N_MODE = N_REF2 + TRFC;
    localparam int N_RDY  = N_MODE + TMRD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, ready;
    logic [AW-1:0] sd_addr;
    logic [BW-1:0] sd_ba;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int cycles = 0;
    int ref_count = 0;
    int pre_count = 0;
    int mode_count = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdram_boot_seq #(
        .ADDR_W(AW), .BANK_W(BW), .T_POWERUP(TPU), .T_RP(TRP), .T_RFC(TRFC),
        .T_MRD(TMRD), .BURST_LEN_CODE(BL), .BURST_INTERLEAVE(BT), .CAS_LATENCY(CL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .ready(ready)
    );

    // reference cycle count since reset release
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: n=%0d actual=%h expected=%h", req, n, act, exp);
        end
    endtask

    // behavioural reference model, compared on every cycle
    always @(negedge clk) begin
        logic [3:0]    e_cmd;
        logic [AW-1:0] e_addr;
        logic          e_rdy;
        string         tag;
        e_cmd  = 4'b0111;  // NOP
        e_addr = '0;
        e_rdy  = 1'b0;
        tag    = "R8";
        if (!rst_n) begin
            tag = "R1";
        end else if (n < N_PRE) begin
            tag = "R2";
        end else if (n == N_PRE) begin
            e_cmd = 4'b0010; e_addr[10] = 1'b1; tag = "R3";
        end else if (n == N_REF1) begin
            e_cmd = 4'b0001; tag = "R4";
        end else if (n == N_REF2) begin
            e_cmd = 4'b0001; tag = "R5";
        end else if (n == N_MODE) begin
            e_cmd = 4'b0000;
            e_addr[2:0] = BL; e_addr[3] = BT; e_addr[6:4] = CL;
            tag = "R6";
        end else if (n >= N_RDY) begin
            e_rdy = 1'b1; tag = "R7";
        end
        if (!done) begin
            check(tag, {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'd0, e_cmd});
            check(tag, 32'(sd_addr), 32'(e_addr));
            check(tag, 32'(sd_ba), 32'd0);
            check(tag, {31'd0, ready}, {31'd0, e_rdy});
            // R10: no activate / read / write
            check("R10", {31'd0, (!sd_cs_n && ((!sd_ras_n && sd_cas_n && sd_we_n) ||
                                              (sd_ras_n && !sd_cas_n)))}, 32'd0);
            if (rst_n && !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n) ref_count++;
            if (rst_n && !sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n) pre_count++;
            if (rst_n && !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n) mode_count++;
        end
    end

    task automatic wait_n(input int target);
        while (n < target) @(negedge clk);
    endtask

    task automatic apply_reset(input int len);
        @(negedge clk);
        #1 rst_n = 1'b0;
        repeat (len) @(negedge clk);
        #1 rst_n = 1'b1;
        ref_count = 0; pre_count = 0; mode_count = 0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        wait (cycles > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: hold reset for several cycles
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        // R9: abort in the middle of the first refresh recovery wait
        wait_n(N_REF1 + 5);
        check("R9", 32'(ref_count), 32'd1);
        apply_reset(3);
        // full run to ready and beyond
        wait_n(N_RDY + 40);
        @(negedge clk);
        check("R5", 32'(ref_count), 32'd2);
        check("R3", 32'(pre_count), 32'd1);
        check("R6", 32'(mode_count), 32'd1);
        // R9: reset after ready restarts everything
        apply_reset(2);
        wait_n(N_PRE + 2);
        @(negedge clk);
        check("R9", 32'(pre_count), 32'd1);
        finish_run();
    end

endmodule